// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

The block links an A-side bus and a B-side bus through two independent one-way paths, A to B and B to A. Each path stores its data in one element per bit. While the path's latch-enable is high, that element passes its input straight through. While latch-enable is low, it acts as a rising-edge register on the path's own capture clock, gated by an active-low clock-enable. So each path can run in transparent, latched, clocked or clock-enabled mode, chosen from cycle to cycle by its four controls.

The capture clock of each path is treated as a control signal, not as a clock. The system clock `clk_i` samples it, and a rise between two samples counts as a capture edge. Outputs are given as data vectors plus per-bit drive-enable vectors. A pad wrapper combines them into tri-state pins.

The data vectors always show the path's value. The drive-enables only decide whether that value reaches the pins. An asynchronous active-low reset clears both stores. It leaves the drive-enables alone.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: While `ab_le_i` is 1, `b_o` equals `a_i` combinationally in the same cycle, whatever `ab_clk_i` and `ab_ce_ni` do.
- R2: While `ab_le_i` is 0 and `ab_clk_i` is held steady, either 0 or 1, `b_o` keeps its stored value whatever `a_i` does.
- R3: With `ab_le_i` = 0 and `ab_ce_ni` = 0, take a `clk_i` edge that samples `ab_clk_i` = 1 when the previous edge sampled 0. That edge captures `a_i`, and the captured value shows on `b_o` right after it.
- R4: While `ab_ce_ni` is 1 and `ab_le_i` is 0, rising edges of `ab_clk_i` are ignored and `b_o` is unchanged.
- R5: `b_oe_o` is all ones while `ab_oe_ni` is 0 and all zeros while it is 1. The same holds for `a_oe_o` and `ba_oe_ni`.
- R6: When `ab_le_i` falls, `b_o` keeps the `a_i` value that the last `clk_i` edge with `ab_le_i` high sampled.
- R7: The B-to-A path behaves the same way, using `b_i`, `a_o`, `a_oe_o`, `ba_oe_ni`, `ba_le_i`, `ba_clk_i` and `ba_ce_ni`. The controls of one path have no effect on the other path.
- R8: Storage keeps capturing while a path's outputs are disabled. The captured value appears on the output once it is enabled.
- R9: A low `rst_ni` at once clears both stores to zero, so a path with latch-enable low shows zero. The drive-enables still follow the output-enable inputs during reset. After reset, a capture clock that is already high does not count as a rising edge.
- R10: A falling edge of `ab_clk_i` never captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all controls |
| rst_ni | input | 1 | Asynchronous active-low reset of both stores |
| a_i | input | W | A-side bus input |
| a_o | output | W | B-to-A path value |
| a_oe_o | output | W | A-side per-bit drive enable |
| b_i | input | W | B-side bus input |
| b_o | output | W | A-to-B path value |
| b_oe_o | output | W | B-side per-bit drive enable |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| ab_le_i | input | 1 | A-to-B latch enable, high is transparent |
| ab_clk_i | input | 1 | A-to-B capture clock |
| ab_ce_ni | input | 1 | A-to-B capture clock enable, active low |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable, high is transparent |
| ba_clk_i | input | 1 | B-to-A capture clock |
| ba_ce_ni | input | 1 | B-to-A capture clock enable, active low |

## Verification
The bench targets the moment latch-enable falls. A store that is only written on capture edges would show stale data there instead of the last transparent value.

It holds the capture clock high across several cycles. A level-triggered capture would then keep following `a_i`. It also drives a falling capture edge, to catch an edge detector with the wrong polarity, and rising edges with the clock-enable high, which a missing gate would let through.

Finally, it captures while the outputs are disabled, drives one path while watching the other, and pulses reset with the output enable active. A design that tied storage to the output enable, crossed the two paths' controls, or reset the drive-enables would show the wrong value in one of these cases.

// File: rtl/bidir_xcvr_pkg.sv
`timescale 1ns/1ps
package bidir_xcvr_pkg;
  typedef struct packed {
    logic oe_n;
    logic le;
    logic pclk;
    logic ce_n;
  } path_ctrl_t;

  localparam int unsigned NUM_DIR = 2;
endpackage

// File: rtl/xcvr_edge_det.sv
`timescale 1ns/1ps
module xcvr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  // history resets high: a level already high at reset release is no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/xcvr_bit_cell.sv
`timescale 1ns/1ps
module xcvr_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic le_i,
  input  logic cap_i,
  output logic y_o
);
  logic q;

  // one store per bit: follows d while transparent, loads on capture otherwise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            q <= 1'b0;
    else if (le_i || cap_i) q <= d_i;
  end

  assign y_o = le_i ? d_i : q;
endmodule

// File: rtl/xcvr_path.sv
`timescale 1ns/1ps
module xcvr_path
  import bidir_xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  path_ctrl_t   ctrl_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] y_o,
  output logic [W-1:0] oe_o
);
  logic pclk_rise;
  logic cap;

  xcvr_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (ctrl_i.pclk),
    .rise_o (pclk_rise)
  );

  assign cap = pclk_rise & ~ctrl_i.ce_n & ~ctrl_i.le;

  for (genvar i = 0; i < W; i++) begin : g_bit
    xcvr_bit_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (d_i[i]),
      .le_i   (ctrl_i.le),
      .cap_i  (cap),
      .y_o    (y_o[i])
    );
  end

  assign oe_o = {W{~ctrl_i.oe_n}};
endmodule

// File: rtl/bidir_latch_xcvr.sv
`timescale 1ns/1ps
module bidir_latch_xcvr
  import bidir_xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o,
  input  logic         ab_oe_ni,
  input  logic         ab_le_i,
  input  logic         ab_clk_i,
  input  logic         ab_ce_ni,
  input  logic         ba_oe_ni,
  input  logic         ba_le_i,
  input  logic         ba_clk_i,
  input  logic         ba_ce_ni
);
  path_ctrl_t   ctrl [NUM_DIR];
  logic [W-1:0] din  [NUM_DIR];
  logic [W-1:0] dout [NUM_DIR];
  logic [W-1:0] doe  [NUM_DIR];

  // index 0: A to B, index 1: B to A
  assign ctrl[0] = '{oe_n: ab_oe_ni, le: ab_le_i, pclk: ab_clk_i, ce_n: ab_ce_ni};
  assign ctrl[1] = '{oe_n: ba_oe_ni, le: ba_le_i, pclk: ba_clk_i, ce_n: ba_ce_ni};
  assign din[0]  = a_i;
  assign din[1]  = b_i;

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    xcvr_path #(.W(W)) u_path (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctrl_i (ctrl[g]),
      .d_i    (din[g]),
      .y_o    (dout[g]),
      .oe_o   (doe[g])
    );
  end

  assign b_o    = dout[0];
  assign b_oe_o = doe[0];
  assign a_o    = dout[1];
  assign a_oe_o = doe[1];
endmodule

// File: rtl/bidir_latch_xcvr_chk.sv
`timescale 1ns/1ps
module bidir_latch_xcvr_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] a_o,
  input logic [W-1:0] a_oe_o,
  input logic [W-1:0] b_i,
  input logic [W-1:0] b_o,
  input logic [W-1:0] b_oe_o,
  input logic         ab_oe_ni,
  input logic         ab_le_i,
  input logic         ab_clk_i,
  input logic         ab_ce_ni,
  input logic         ba_oe_ni,
  input logic         ba_le_i,
  input logic         ba_clk_i,
  input logic         ba_ce_ni
);
  assert_le_fall_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_le_i && $past(ab_le_i) && $past(rst_ni)) |-> (b_o == $past(a_i)));

  assert_ab_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_le_i && !ab_ce_ni && ab_clk_i && !$past(ab_clk_i) && $past(rst_ni))
    |=> (ab_le_i || b_o == $past(a_i)));

  assert_ab_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_le_i && !(!ab_ce_ni && ab_clk_i && !$past(ab_clk_i)))
    |=> (ab_le_i || $stable(b_o)));

  assert_ba_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ba_le_i && !ba_ce_ni && ba_clk_i && !$past(ba_clk_i) && $past(rst_ni))
    |=> (ba_le_i || a_o == $past(b_i)));

  assert_ab_oe_R5: assert property (@(posedge clk_i)
    ab_oe_ni |-> (b_oe_o == '0));

  assert_ba_oe_R5: assert property (@(posedge clk_i)
    !ba_oe_ni |-> (a_oe_o == '1));
endmodule

bind bidir_latch_xcvr bidir_latch_xcvr_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .a_o      (a_o),
  .a_oe_o   (a_oe_o),
  .b_i      (b_i),
  .b_o      (b_o),
  .b_oe_o   (b_oe_o),
  .ab_oe_ni (ab_oe_ni),
  .ab_le_i  (ab_le_i),
  .ab_clk_i (ab_clk_i),
  .ab_ce_ni (ab_ce_ni),
  .ba_oe_ni (ba_oe_ni),
  .ba_le_i  (ba_le_i),
  .ba_clk_i (ba_clk_i),
  .ba_ce_ni (ba_ce_ni)
);

// File: tb/bidir_latch_xcvr_tb.sv
`timescale 1ns/1ps
module bidir_latch_xcvr_tb;
  localparam int unsigned W = 18;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [W-1:0] a_i, b_i, a_o, b_o, a_oe_o, b_oe_o;
  logic         ab_oe_ni, ab_le_i, ab_clk_i, ab_ce_ni;
  logic         ba_oe_ni, ba_le_i, ba_clk_i, ba_ce_ni;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bidir_latch_xcvr #(.W(W)) u_dut (
    .clk_i, .rst_ni, .a_i, .a_o, .a_oe_o, .b_i, .b_o, .b_oe_o,
    .ab_oe_ni, .ab_le_i, .ab_clk_i, .ab_ce_ni,
    .ba_oe_ni, .ba_le_i, .ba_clk_i, .ba_ce_ni
  );

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0;
    a_i = '0; b_i = '0;
    ab_oe_ni = 1'b1; ab_le_i = 1'b0; ab_clk_i = 1'b0; ab_ce_ni = 1'b1;
    ba_oe_ni = 1'b1; ba_le_i = 1'b0; ba_clk_i = 1'b0; ba_ce_ni = 1'b1;
    repeat (3) step();
    chk("R9 reset b_o", b_o, '0);
    chk("R9 reset a_o", a_o, '0);
    chk("R5 reset b_oe_o", b_oe_o, '0);
    rst_ni = 1'b1;
    step();
  endtask

  task automatic t_transparent();
    ab_le_i = 1'b1; a_i = 18'h2A5A5; #1;
    chk("R1 transparent", b_o, 18'h2A5A5);
    ab_clk_i = 1'b1; ab_ce_ni = 1'b0;
    step();
    a_i = 18'h15A5A; #1;
    chk("R1 transparent with clock edge", b_o, 18'h15A5A);
    ab_clk_i = 1'b0;
    step();
  endtask

  task automatic t_latch_hold();
    a_i = 18'h3C3C3;
    step();
    ab_le_i = 1'b0;
    step();
    a_i = 18'h00FFF;
    step();
    chk("R6 value kept after le falls", b_o, 18'h3C3C3);
    ab_ce_ni = 1'b1; ab_clk_i = 1'b1;
    step();
    ab_ce_ni = 1'b0;
    step(); step();
    chk("R2 clock held high", b_o, 18'h3C3C3);
    ab_clk_i = 1'b0;
    step();
    chk("R2 clock held low", b_o, 18'h3C3C3);
  endtask

  task automatic t_capture();
    ab_clk_i = 1'b1;
    step();
    chk("R3 capture on rise", b_o, 18'h00FFF);
    a_i = 18'h11111;
    step();
    chk("R2 no capture while high", b_o, 18'h00FFF);
    ab_clk_i = 1'b0;
    step();
    chk("R10 falling edge ignored", b_o, 18'h00FFF);
  endtask

  task automatic t_ce_block();
    ab_ce_ni = 1'b1; a_i = 18'h2BEEF;
    ab_clk_i = 1'b1;
    step();
    chk("R4 rise ignored with ce high", b_o, 18'h00FFF);
    ab_clk_i = 1'b0;
    step();
    ab_ce_ni = 1'b0; ab_clk_i = 1'b1;
    step();
    chk("R3 capture after ce low", b_o, 18'h2BEEF);
    ab_clk_i = 1'b0;
    step();
  endtask

  task automatic t_oe();
    ab_oe_ni = 1'b0; #1;
    chk("R5 b_oe_o on", b_oe_o, '1);
    chk("R7 a_oe_o untouched", a_oe_o, '0);
    ab_oe_ni = 1'b1; #1;
    chk("R5 b_oe_o off", b_oe_o, '0);
  endtask

  task automatic t_disabled_update();
    a_i = 18'h12345; ab_clk_i = 1'b1;
    step();
    ab_clk_i = 1'b0; ab_oe_ni = 1'b0;
    step();
    chk("R8 b_oe_o after enable", b_oe_o, '1);
    chk("R8 captured while disabled", b_o, 18'h12345);
  endtask

  task automatic t_mirror();
    b_i = 18'h3A5A5; ba_le_i = 1'b1; #1;
    chk("R7 b to a transparent", a_o, 18'h3A5A5);
    chk("R7 a to b untouched", b_o, 18'h12345);
    step();
    ba_le_i = 1'b0;
    step();
    b_i = '0;
    step();
    chk("R7 b to a latched", a_o, 18'h3A5A5);
    ba_ce_ni = 1'b0; ba_clk_i = 1'b1;
    step();
    chk("R7 b to a capture", a_o, '0);
    chk("R7 a to b unchanged", b_o, 18'h12345);
    ba_oe_ni = 1'b0; #1;
    chk("R5 a_oe_o on", a_oe_o, '1);
  endtask

  task automatic t_reset_mid();
    b_i = 18'h0BEEF;
    rst_ni = 1'b0; #1;
    chk("R9 async clear b_o", b_o, '0);
    chk("R9 oe kept in reset", b_oe_o, '1);
    step();
    rst_ni = 1'b1;
    step();
    chk("R9 high clock at release no edge", a_o, '0);
  endtask

  initial begin
    t_reset_state();
    t_transparent();
    t_latch_hold();
    t_capture();
    t_ce_block();
    t_oe();
    t_disabled_update();
    t_mirror();
    t_reset_mid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule